// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block tracks which physical registers hold a final value and which waiting consumer instructions can therefore proceed. Each tracked register has one ready bit. Claiming a register as the destination of a new producer clears its bit, and a completion broadcast on that register sets it again. A consumer is written into one of a fixed number of entries together with its source register tags and the readiness that rename assigned to each source. The entry then watches the completion broadcast. Each source compares its own tag against the broadcast, which replaces a linked list of waiters per register.

When a consumer is written, each of its sources is checked again against the scoreboard and against a completion arriving in the same cycle. This catches operands that became ready while the instruction was travelling between stages. Tags at or beyond the physical register count are never tracked. Such a source counts as ready. Such an allocation or completion leaves the scoreboard unchanged. A consumer whose sources are all ready raises its issue line. A memory consumer raises a separate memory line instead. Choosing among ready entries and allocating free entries belong to the surrounding queue. That queue releases an entry when the entry issues or is squashed.

Top module: `wakeup_board`

## Requirements
- R1: After reset every scoreboard bit is 0 and no entry drives `issue_rdy` or `mem_rdy`.
- R2: An allocation of a tracked tag makes that register's bit in `preg_rdy` 0 from the next cycle. When an allocation and a completion name the same tag in the same cycle, the allocation wins.
- R3: A completion of a tracked tag makes that register's bit in `preg_rdy` 1 from the next cycle.
- R4: A tag is tracked only when its value is below `NUM_PREGS`. An allocation or completion of any other tag leaves `preg_rdy` unchanged. A source with such a tag is ready when it is inserted.
- R5: When a consumer is inserted, a source flagged not-ready by `ins_rdy` is stored as ready if its scoreboard bit is already set or if a completion of the same tag arrives in the insert cycle.
- R6: A source that is stored as waiting becomes ready in the cycle after a completion carrying its tag. The entry's output rises in that same cycle when that source was the last one missing.
- R7: `issue_rdy[k]` is 1 exactly when entry k holds a non-memory consumer whose sources are all ready. It is visible from the cycle after the insert. Source i is taken from `ins_tags[i*TAG_W +: TAG_W]` and `ins_rdy[i]`.
- R8: An entry inserted with `ins_mem`=1 signals readiness on `mem_rdy[k]` and never on `issue_rdy[k]`.
- R9: `alloc_conflict` is 1 in the same cycle as `alloc_vld` when any valid entry still has a waiting source with the allocated tag. Otherwise it is 0.
- R10: Releasing entry k (issue or squash) removes it from all waiting, so later completions do not raise its outputs and it no longer counts for `alloc_conflict`. An insert to the same entry in the same cycle takes priority over the release.
- R11: A single completion wakes every waiting source with that tag, across entries and within one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Claim a destination register for a new producer |
| alloc_tag | input | TAG_W | Destination register tag being claimed |
| alloc_conflict | output | 1 | Claimed tag still has waiting consumers (combinational) |
| ins_vld | input | 1 | Write a consumer into an entry |
| ins_slot | input | SLOT_W | Entry index to write |
| ins_mem | input | 1 | Consumer is a memory reference |
| ins_tags | input | NUM_SRCS*TAG_W | Source register tags, source i in bits i*TAG_W upward |
| ins_rdy | input | NUM_SRCS | Readiness of each source as seen by rename |
| cmp_vld | input | 1 | Completion broadcast valid |
| cmp_tag | input | TAG_W | Destination tag of the completing producer |
| rel_vld | input | 1 | Release an entry (issued or squashed) |
| rel_slot | input | SLOT_W | Entry index to release |
| preg_rdy | output | NUM_PREGS | Scoreboard ready bit per tracked register |
| issue_rdy | output | NUM_SLOTS | Entry holds a non-memory consumer with all sources ready |
| mem_rdy | output | NUM_SLOTS | Entry holds a memory consumer with all sources ready |

## Verification
Every state change takes one register stage. An allocation, completion, insert or release in cycle N shows on `preg_rdy`, `issue_rdy` and `mem_rdy` in cycle N+1. `alloc_conflict` is the only combinational result and belongs to the cycle in which the allocation is driven. The bench drives inputs just after a falling edge and steps through exactly one rising edge. It then samples the registered outputs at the following falling edge. It samples `alloc_conflict` a short delay after driving, before the rising edge. This puts each check in the first cycle in which the result is due. No check waits extra cycles that could hide a late result.

// File: rtl/wakeup_pkg.sv
package wakeup_pkg;
   // default geometry shared by the board, its checker and the bench
   localparam int unsigned DEF_PREGS = 16;
   localparam int unsigned DEF_TAG_W = 5;
   localparam int unsigned DEF_SLOTS = 4;
   localparam int unsigned DEF_SRCS  = 2;

   // route taken by a consumer once all of its operands are present
   typedef enum logic {
      ROUTE_EXEC = 1'b0,
      ROUTE_MEM  = 1'b1
   } route_t;
endpackage

// File: rtl/wakeup_sb_bits.sv
module wakeup_sb_bits #(
   parameter int unsigned NUM_PREGS = wakeup_pkg::DEF_PREGS,
   parameter int unsigned TAG_W     = wakeup_pkg::DEF_TAG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_vld,
   input  logic [TAG_W-1:0]     alloc_tag,
   input  logic                 cmp_vld,
   input  logic [TAG_W-1:0]     cmp_tag,
   output logic [NUM_PREGS-1:0] rdy_bits
);
   if (NUM_PREGS > (1 << TAG_W)) begin : g_bad_tag_w
      $error("wakeup_sb_bits: TAG_W too narrow for NUM_PREGS");
   end

   // tags at or above NUM_PREGS never match any bit position below
   for (genvar r = 0; r < NUM_PREGS; r++) begin : g_bit
      logic hit_alloc, hit_cmp;
      assign hit_alloc = alloc_vld && (alloc_tag == TAG_W'(r));
      assign hit_cmp   = cmp_vld   && (cmp_tag   == TAG_W'(r));

      always_ff @(posedge clk) begin
         if (!rst_n)         rdy_bits[r] <= 1'b0;
         else if (hit_alloc) rdy_bits[r] <= 1'b0;   // new producer wins
         else if (hit_cmp)   rdy_bits[r] <= 1'b1;
      end
   end
endmodule

// File: rtl/wakeup_slot.sv
module wakeup_slot #(
   parameter int unsigned TAG_W    = wakeup_pkg::DEF_TAG_W,
   parameter int unsigned NUM_SRCS = wakeup_pkg::DEF_SRCS
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      load_mem,
   input  logic [NUM_SRCS*TAG_W-1:0] load_tags,
   input  logic [NUM_SRCS-1:0]       load_rdy,
   input  logic                      drop,
   input  logic                      wake_vld,
   input  logic [TAG_W-1:0]          wake_tag,
   input  logic [TAG_W-1:0]          probe_tag,
   output logic                      valid_o,
   output logic                      all_rdy_o,
   output logic                      is_mem_o,
   output logic                      probe_hit_o
);
   import wakeup_pkg::*;

   logic                      vld_q;
   route_t                    route_q;
   logic [NUM_SRCS*TAG_W-1:0] tags_q;
   logic [NUM_SRCS-1:0]       rdy_q;
   logic [NUM_SRCS-1:0]       wake_hit;
   logic [NUM_SRCS-1:0]       probe_src;

   for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
      logic [TAG_W-1:0] tag_s;
      assign tag_s        = tags_q[s*TAG_W +: TAG_W];
      assign wake_hit[s]  = wake_vld && vld_q && !rdy_q[s] && (tag_s == wake_tag);
      assign probe_src[s] = vld_q && !rdy_q[s] && (tag_s == probe_tag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         route_q <= ROUTE_EXEC;
         tags_q  <= '0;
         rdy_q   <= '0;
      end else if (load) begin
         vld_q   <= 1'b1;
         route_q <= load_mem ? ROUTE_MEM : ROUTE_EXEC;
         tags_q  <= load_tags;
         rdy_q   <= load_rdy;
      end else begin
         if (drop) vld_q <= 1'b0;
         rdy_q <= rdy_q | wake_hit;
      end
   end

   assign valid_o     = vld_q;
   assign all_rdy_o   = &rdy_q;
   assign is_mem_o    = (route_q == ROUTE_MEM);
   assign probe_hit_o = |probe_src;
endmodule

// File: rtl/wakeup_board.sv
module wakeup_board #(
   parameter int unsigned NUM_PREGS = wakeup_pkg::DEF_PREGS,
   parameter int unsigned TAG_W     = wakeup_pkg::DEF_TAG_W,
   parameter int unsigned NUM_SLOTS = wakeup_pkg::DEF_SLOTS,
   parameter int unsigned NUM_SRCS  = wakeup_pkg::DEF_SRCS,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc_vld,
   input  logic [TAG_W-1:0]          alloc_tag,
   output logic                      alloc_conflict,
   input  logic                      ins_vld,
   input  logic [SLOT_W-1:0]         ins_slot,
   input  logic                      ins_mem,
   input  logic [NUM_SRCS*TAG_W-1:0] ins_tags,
   input  logic [NUM_SRCS-1:0]       ins_rdy,
   input  logic                      cmp_vld,
   input  logic [TAG_W-1:0]          cmp_tag,
   input  logic                      rel_vld,
   input  logic [SLOT_W-1:0]         rel_slot,
   output logic [NUM_PREGS-1:0]      preg_rdy,
   output logic [NUM_SLOTS-1:0]      issue_rdy,
   output logic [NUM_SLOTS-1:0]      mem_rdy
);
   localparam int unsigned IDX_W = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1;
   localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_PREGS);

   if (NUM_SLOTS < 2)                  begin : g_bad_slots $error("wakeup_board: NUM_SLOTS must be >= 2"); end
   if (NUM_SRCS < 1)                   begin : g_bad_srcs  $error("wakeup_board: NUM_SRCS must be >= 1");  end
   if (NUM_PREGS > (1 << TAG_W))       begin : g_bad_tags  $error("wakeup_board: TAG_W too narrow");       end
   if (IDX_W > TAG_W)                  begin : g_bad_idx   $error("wakeup_board: index wider than tag");   end

   // scoreboard
   wakeup_sb_bits #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
      .cmp_vld(cmp_vld), .cmp_tag(cmp_tag),
      .rdy_bits(preg_rdy)
   );

   // operand recheck at insert: rename flag, scoreboard, same-cycle broadcast
   logic [NUM_SRCS-1:0] res_rdy;
   for (genvar s = 0; s < NUM_SRCS; s++) begin : g_chk
      logic [TAG_W-1:0] tag_s;
      logic             tracked, sb_hit, bypass;
      assign tag_s   = ins_tags[s*TAG_W +: TAG_W];
      assign tracked = ({1'b0, tag_s} < LIMIT);
      assign sb_hit  = tracked && preg_rdy[tag_s[IDX_W-1:0]];
      assign bypass  = cmp_vld && (cmp_tag == tag_s);
      assign res_rdy[s] = ins_rdy[s] || !tracked || sb_hit || bypass;
   end

   // consumer entries
   logic [NUM_SLOTS-1:0] ent_vld, ent_all, ent_mem, ent_probe;
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_ent
      logic ld, dr;
      assign ld = ins_vld && (ins_slot == SLOT_W'(k));
      assign dr = rel_vld && (rel_slot == SLOT_W'(k));

      wakeup_slot #(.TAG_W(TAG_W), .NUM_SRCS(NUM_SRCS)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .load(ld), .load_mem(ins_mem), .load_tags(ins_tags), .load_rdy(res_rdy),
         .drop(dr),
         .wake_vld(cmp_vld), .wake_tag(cmp_tag),
         .probe_tag(alloc_tag),
         .valid_o(ent_vld[k]), .all_rdy_o(ent_all[k]),
         .is_mem_o(ent_mem[k]), .probe_hit_o(ent_probe[k])
      );

      assign issue_rdy[k] = ent_vld[k] && ent_all[k] && !ent_mem[k];
      assign mem_rdy[k]   = ent_vld[k] && ent_all[k] &&  ent_mem[k];
   end

   assign alloc_conflict = alloc_vld && (|ent_probe);
endmodule

// File: rtl/wakeup_board_chk.sv
module wakeup_board_chk #(
   parameter int unsigned NUM_PREGS = wakeup_pkg::DEF_PREGS,
   parameter int unsigned TAG_W     = wakeup_pkg::DEF_TAG_W,
   parameter int unsigned NUM_SLOTS = wakeup_pkg::DEF_SLOTS,
   parameter int unsigned NUM_SRCS  = wakeup_pkg::DEF_SRCS,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      alloc_vld,
   input logic [TAG_W-1:0]          alloc_tag,
   input logic                      alloc_conflict,
   input logic                      ins_vld,
   input logic [SLOT_W-1:0]         ins_slot,
   input logic                      ins_mem,
   input logic [NUM_SRCS*TAG_W-1:0] ins_tags,
   input logic [NUM_SRCS-1:0]       ins_rdy,
   input logic                      cmp_vld,
   input logic [TAG_W-1:0]          cmp_tag,
   input logic                      rel_vld,
   input logic [SLOT_W-1:0]         rel_slot,
   input logic [NUM_PREGS-1:0]      preg_rdy,
   input logic [NUM_SLOTS-1:0]      issue_rdy,
   input logic [NUM_SLOTS-1:0]      mem_rdy
);
   localparam int unsigned IDX_W = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1;
   localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_PREGS);

   logic             a_trk, c_trk, same_tag;
   logic [IDX_W-1:0] a_idx, c_idx;
   assign a_trk    = alloc_vld && ({1'b0, alloc_tag} < LIMIT);
   assign c_trk    = cmp_vld   && ({1'b0, cmp_tag}   < LIMIT);
   assign same_tag = alloc_vld && (alloc_tag == cmp_tag);
   assign a_idx    = alloc_tag[IDX_W-1:0];
   assign c_idx    = cmp_tag[IDX_W-1:0];

   assert_alloc_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      a_trk |=> !preg_rdy[$past(a_idx)]);

   assert_cmp_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (c_trk && !same_tag) |=> preg_rdy[$past(c_idx)]);

   assert_untracked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_trk && !c_trk) |=> $stable(preg_rdy));

   assert_mem_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_vld && ins_mem) |=> !issue_rdy[$past(ins_slot)]);

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vld && !(ins_vld && ins_slot == rel_slot))
         |=> (!issue_rdy[$past(rel_slot)] && !mem_rdy[$past(rel_slot)]));

   assert_conflict_needs_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_conflict |-> alloc_vld);
endmodule

bind wakeup_board wakeup_board_chk #(
   .NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS), .NUM_SRCS(NUM_SRCS)
) u_chk (.*);

// File: tb/wakeup_board_tb.sv
`timescale 1ns/1ps
module wakeup_board_tb;
   localparam int NP = 16, TW = 5, NS = 4, NSRC = 2, SW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_vld, ins_vld, ins_mem, cmp_vld, rel_vld, alloc_conflict;
   logic [TW-1:0] alloc_tag, cmp_tag;
   logic [SW-1:0] ins_slot, rel_slot;
   logic [NSRC*TW-1:0] ins_tags;
   logic [NSRC-1:0] ins_rdy;
   logic [NP-1:0] preg_rdy;
   logic [NS-1:0] issue_rdy, mem_rdy;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wakeup_board u_dut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      alloc_vld = 0; alloc_tag = '0; ins_vld = 0; ins_slot = '0; ins_mem = 0;
      ins_tags = '0; ins_rdy = '0; cmp_vld = 0; cmp_tag = '0; rel_vld = 0; rel_slot = '0;
   endtask

   // one rising edge, then back to the falling edge with inputs idle
   task automatic cyc();
      @(posedge clk); @(negedge clk); idle_inputs();
   endtask

   task automatic do_ins(int slot, int t1, int t0, logic [1:0] rdy, logic mem);
      ins_vld = 1; ins_slot = SW'(slot); ins_tags = {TW'(t1), TW'(t0)}; ins_rdy = rdy; ins_mem = mem;
   endtask

   task automatic t_reset();
      check("R1 preg_rdy", 32'(preg_rdy), 0);
      check("R1 issue_rdy", 32'(issue_rdy), 0);
      check("R1 mem_rdy", 32'(mem_rdy), 0);
   endtask

   task automatic t_scoreboard();
      alloc_vld = 1; alloc_tag = 3; cyc();
      check("R2 alloc clears", 32'(preg_rdy), 0);
      cmp_vld = 1; cmp_tag = 3; cyc();
      check("R3 completion sets", 32'(preg_rdy), 32'h8);
      alloc_vld = 1; alloc_tag = 3; cmp_vld = 1; cmp_tag = 3; cyc();
      check("R2 alloc beats completion", 32'(preg_rdy), 0);
      cmp_vld = 1; cmp_tag = 3; cyc();
      cmp_vld = 1; cmp_tag = 20; cyc();
      check("R4 untracked completion", 32'(preg_rdy), 32'h8);
      alloc_vld = 1; alloc_tag = 20; cyc();
      check("R4 untracked alloc", 32'(preg_rdy), 32'h8);
   endtask

   task automatic t_recheck();
      do_ins(0, 3, 17, 2'b00, 0); cyc();   // src1=3 set in board, src0=17 untracked
      check("R5 R4 R7 recheck ready", 32'(issue_rdy), 32'h1);
      rel_vld = 1; rel_slot = 0; cyc();
      check("R10 release clears", 32'(issue_rdy), 0);
   endtask

   task automatic t_wake();
      do_ins(1, 6, 5, 2'b00, 0); cyc();
      do_ins(2, 5, 5, 2'b00, 1); cyc();
      check("R7 waiting not ready", 32'(issue_rdy), 0);
      check("R8 waiting mem not ready", 32'(mem_rdy), 0);
      alloc_vld = 1; alloc_tag = 5; #1;
      check("R9 conflict raised", 32'(alloc_conflict), 1);
      cyc();
      alloc_vld = 1; alloc_tag = 7; #1;
      check("R9 no conflict", 32'(alloc_conflict), 0);
      cyc();
      cmp_vld = 1; cmp_tag = 5; cyc();
      check("R8 R11 mem route both srcs", 32'(mem_rdy), 32'h4);
      check("R6 partial wake", 32'(issue_rdy), 0);
      cmp_vld = 1; cmp_tag = 6; cyc();
      check("R6 last source wakes", 32'(issue_rdy), 32'h2);
      check("R3 board after wakes", 32'(preg_rdy), 32'h68);
   endtask

   task automatic t_bypass();
      do_ins(3, 8, 8, 2'b00, 0); cmp_vld = 1; cmp_tag = 8; cyc();
      check("R5 same-cycle bypass", 32'(issue_rdy), 32'ha);
   endtask

   task automatic t_squash();
      for (int k = 1; k < 4; k++) begin rel_vld = 1; rel_slot = SW'(k); cyc(); end
      check("R10 all released issue", 32'(issue_rdy), 0);
      check("R10 all released mem", 32'(mem_rdy), 0);
      do_ins(0, 3, 9, 2'b00, 0); cyc();
      check("R7 waits on 9", 32'(issue_rdy), 0);
      rel_vld = 1; rel_slot = 0; cyc();
      alloc_vld = 1; alloc_tag = 9; #1;
      check("R10 squashed not waiting", 32'(alloc_conflict), 0);
      cyc();
      cmp_vld = 1; cmp_tag = 9; cyc();
      check("R10 no wake after squash", 32'(issue_rdy | mem_rdy), 0);
      do_ins(1, 3, 3, 2'b00, 0); rel_vld = 1; rel_slot = 1; cyc();
      check("R10 insert beats release", 32'(issue_rdy), 32'h2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_scoreboard();
      t_recheck();
      t_wake();
      t_bypass();
      t_squash();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule